// File: doc/BRIEF.md
# Associative Memory Road Finder

This block is a content-addressable pattern matcher used to find candidate particle tracks ("roads") in a layered detector. It stores a bank of patterns. Each pattern holds one coarse 16-bit word for each of the eight detector layers. During an event, hit words arrive on eight independent layer buses. On every clock cycle, every stored word is compared in parallel against the bus of its own layer. A match sets a per-layer flag on that pattern, and the flag stays set until the event is cleared.

When the event-end pulse arrives, the block stops accepting hits. A pattern counts as a road when its number of matched layers reaches a programmable majority threshold, so a road does not need a hit on every layer. The road IDs are then streamed out over a valid/ready interface, lowest index first. The stream ends with an end-of-roads beat. Accepting that beat wipes every match flag and returns the block to collecting the next event.

Top module: `am_road_finder`

## Requirements
- R1: While collecting, a cycle with `ld_we` high writes `ld_word` into layer `ld_layer` of pattern `ld_pat`. Reset sets every stored word of every pattern to zero.
- R2: While collecting, for each layer whose bit in `hit_vld` is high, every pattern whose stored word for that layer equals that layer's slice of `hit_bus` sets its flag for that layer. Layer i uses bits [16*i+15:16*i]. Flags stay set until the event is cleared.
- R3: A pattern is a road when the number of its set layer flags is greater than or equal to the threshold.
- R4: A `thr_we` cycle with `thr_val` in 1..8 updates the threshold while collecting. Any other value is ignored. Reset sets the threshold to 8.
- R5: While collecting, `rd_vld` is low. An `evt_end` pulse moves the block to readout on the next cycle, and hits presented in the same cycle as `evt_end` still count.
- R6: In readout, roads appear on `rd_id` with `rd_eor` low, one road per accepted beat (`rd_vld` and `rd_rdy` both high), in strictly ascending index order.
- R7: After the last road, one beat appears with `rd_eor` high and `rd_id` zero. Accepting that beat clears all flags, and `rd_vld` is low in the next cycle.
- R8: While `rd_vld` is high and `rd_rdy` is low, `rd_id` and `rd_eor` hold their values.
- R9: During readout, hits, pattern writes, threshold writes and `evt_end` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Pattern word write strobe |
| ld_pat | input | 4 | Pattern index to write |
| ld_layer | input | 3 | Layer index to write |
| ld_word | input | 16 | Word to store |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | 4 | New majority threshold |
| hit_vld | input | 8 | Per-layer hit valid |
| hit_bus | input | 128 | Eight 16-bit layer hit words, layer 0 in the low bits |
| evt_end | input | 1 | End of event, starts readout |
| rd_rdy | input | 1 | Consumer ready for a road beat |
| rd_vld | output | 1 | Road beat valid |
| rd_id | output | 4 | Road pattern index |
| rd_eor | output | 1 | End-of-roads marker beat |

## Verification
The bench targets several corner cases:
- **Threshold values 0 and 9.** A design that accepted either would stop matching entirely or would flag every pattern.
- **Threshold of one against threshold of eight.** This exposes an off-by-one in the majority compare: the design would drop exact-threshold roads or add roads one layer short.
- **Hits, writes and a second `evt_end` during a stalled readout.** A design that did not freeze its state would change the road list in mid-stream.
- **An empty event straight after a full one.** This shows whether flags survive the end-of-roads beat.
- **Random backpressure.** This catches an ID that moves while stalled, as well as a skipped or repeated road.

// File: rtl/am_pkg.sv
`timescale 1ns/1ps
package am_pkg;
   typedef enum logic {
      ST_COLLECT = 1'b0,
      ST_READOUT = 1'b1
   } am_state_e;
endpackage

// File: rtl/am_pattern_slot.sv
`timescale 1ns/1ps
module am_pattern_slot #(
   parameter int NUM_LAYERS = 8,
   parameter int WORD_W     = 16,
   parameter int LAYER_W    = $clog2(NUM_LAYERS),
   parameter int CNT_W      = $clog2(NUM_LAYERS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [LAYER_W-1:0]           wr_layer,
   input  logic [WORD_W-1:0]            wr_word,
   input  logic [NUM_LAYERS-1:0]        hit_vld,
   input  logic [NUM_LAYERS*WORD_W-1:0] hit_bus,
   input  logic                         match_en,
   input  logic                         clr,
   input  logic [CNT_W-1:0]             thresh,
   output logic                         road
);
   logic [WORD_W-1:0]     words [NUM_LAYERS];
   logic [NUM_LAYERS-1:0] hit_eq;
   logic [NUM_LAYERS-1:0] flags;
   logic [CNT_W-1:0]      cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LAYERS; i++) words[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_LAYERS; i++)
            if (wr_layer == LAYER_W'(i)) words[i] <= wr_word;
      end
   end

   for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_cmp
      assign hit_eq[g] = hit_vld[g] && (hit_bus[g*WORD_W +: WORD_W] == words[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags <= '0;
      else if (clr)      flags <= '0;
      else if (match_en) flags <= flags | hit_eq;
   end

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NUM_LAYERS; i++) cnt = cnt + CNT_W'(flags[i]);
   end

   assign road = (cnt >= thresh);

   // R2
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/am_lowest_pick.sv
`timescale 1ns/1ps
module am_lowest_pick #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (req[i]) idx = IW'(i);
   end
endmodule

// File: rtl/am_readout.sv
`timescale 1ns/1ps
module am_readout
   import am_pkg::*;
#(
   parameter int NUM_PAT = 16,
   parameter int IDX_W   = $clog2(NUM_PAT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_PAT-1:0] road_vec,
   input  logic               evt_end,
   input  logic               rd_rdy,
   output logic               in_ro,
   output logic               flag_clr,
   output logic               rd_vld,
   output logic [IDX_W-1:0]   rd_id,
   output logic               rd_eor
);
   am_state_e          state;
   logic [NUM_PAT-1:0] served;
   logic [NUM_PAT-1:0] pending;
   logic               has;
   logic [IDX_W-1:0]   pick;
   logic               accept;

   assign pending = road_vec & ~served;

   am_lowest_pick #(.N(NUM_PAT), .IW(IDX_W)) u_pick (
      .req (pending),
      .any (has),
      .idx (pick)
   );

   assign in_ro    = (state == ST_READOUT);
   assign rd_vld   = in_ro;
   assign rd_eor   = in_ro && !has;
   assign rd_id    = (in_ro && has) ? pick : '0;
   assign accept   = rd_vld && rd_rdy;
   assign flag_clr = accept && !has;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_COLLECT;
         served <= '0;
      end else if (state == ST_COLLECT) begin
         served <= '0;
         if (evt_end) state <= ST_READOUT;
      end else if (accept) begin
         if (has) begin
            served[pick] <= 1'b1;
         end else begin
            served <= '0;
            state  <= ST_COLLECT;
         end
      end
   end

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && !rd_rdy) |=> ($stable(rd_id) && $stable(rd_eor) && rd_vld));

   // R6
   ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && rd_rdy && !rd_eor) |=> (rd_eor || (rd_id > $past(rd_id))));

   // R7
   eor_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && rd_rdy && rd_eor) |=> !rd_vld);
endmodule

// File: rtl/am_road_finder.sv
`timescale 1ns/1ps
module am_road_finder #(
   parameter int NUM_PAT    = 16,
   parameter int NUM_LAYERS = 8,
   parameter int WORD_W     = 16,
   localparam int IDX_W     = $clog2(NUM_PAT),
   localparam int LAYER_W   = $clog2(NUM_LAYERS),
   localparam int CNT_W     = $clog2(NUM_LAYERS + 1),
   localparam int BUS_W     = NUM_LAYERS * WORD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_we,
   input  logic [IDX_W-1:0]      ld_pat,
   input  logic [LAYER_W-1:0]    ld_layer,
   input  logic [WORD_W-1:0]     ld_word,
   input  logic                  thr_we,
   input  logic [CNT_W-1:0]      thr_val,
   input  logic [NUM_LAYERS-1:0] hit_vld,
   input  logic [BUS_W-1:0]      hit_bus,
   input  logic                  evt_end,
   input  logic                  rd_rdy,
   output logic                  rd_vld,
   output logic [IDX_W-1:0]      rd_id,
   output logic                  rd_eor
);
   if (NUM_PAT < 2)    begin : g_bad_pat   $error("NUM_PAT must be at least 2");    end
   if (NUM_LAYERS < 2) begin : g_bad_layer $error("NUM_LAYERS must be at least 2"); end
   if (WORD_W < 1)     begin : g_bad_word  $error("WORD_W must be positive");       end

   logic               in_ro;
   logic               flag_clr;
   logic [CNT_W-1:0]   thresh;
   logic [NUM_PAT-1:0] road_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thresh <= CNT_W'(NUM_LAYERS);
      else if (thr_we && !in_ro && (thr_val != '0) && (thr_val <= CNT_W'(NUM_LAYERS)))
         thresh <= thr_val;
   end

   for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      am_pattern_slot #(
         .NUM_LAYERS (NUM_LAYERS),
         .WORD_W     (WORD_W),
         .LAYER_W    (LAYER_W),
         .CNT_W      (CNT_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (ld_we && !in_ro && (ld_pat == IDX_W'(p))),
         .wr_layer (ld_layer),
         .wr_word  (ld_word),
         .hit_vld  (hit_vld),
         .hit_bus  (hit_bus),
         .match_en (!in_ro),
         .clr      (flag_clr),
         .thresh   (thresh),
         .road     (road_vec[p])
      );
   end

   am_readout #(.NUM_PAT(NUM_PAT), .IDX_W(IDX_W)) u_ro (
      .clk      (clk),
      .rst_n    (rst_n),
      .road_vec (road_vec),
      .evt_end  (evt_end),
      .rd_rdy   (rd_rdy),
      .in_ro    (in_ro),
      .flag_clr (flag_clr),
      .rd_vld   (rd_vld),
      .rd_id    (rd_id),
      .rd_eor   (rd_eor)
   );

   // R4
   thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh != '0) && (thresh <= CNT_W'(NUM_LAYERS)));

   // R9
   ro_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ro && !flag_clr) |=> $stable(road_vec));
endmodule

// File: tb/sim_am_road_finder.sv
`timescale 1ns/1ps
module sim_am_road_finder;
   localparam int NP = 16, NL = 8, WW = 16, IW = 4, LW = 3, CW = 4;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           ld_we;
   logic [IW-1:0]  ld_pat;
   logic [LW-1:0]  ld_layer;
   logic [WW-1:0]  ld_word;
   logic           thr_we;
   logic [CW-1:0]  thr_val;
   logic [NL-1:0]  hit_vld;
   logic [NL*WW-1:0] hit_bus;
   logic           evt_end;
   logic           rd_rdy;
   logic           rd_vld;
   logic [IW-1:0]  rd_id;
   logic           rd_eor;

   am_road_finder #(.NUM_PAT(NP), .NUM_LAYERS(NL), .WORD_W(WW)) u0 (.*);

   always #2.5 clk = ~clk;

   int nchk = 0, nfail = 0;
   bit finished = 0;
   logic [WW-1:0] mbank [NP][NL];
   logic [NL-1:0] mflags [NP];
   int mthr;

   function automatic int popc(logic [NL-1:0] v);
      int c = 0;
      for (int i = 0; i < NL; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic logic [NL*WW-1:0] small_bus();
      logic [NL*WW-1:0] b;
      for (int i = 0; i < NL; i++) b[i*WW +: WW] = WW'($urandom % 4);
      return b;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ld_we = 0; ld_pat = '0; ld_layer = '0; ld_word = '0;
      thr_we = 0; thr_val = '0; hit_vld = '0; hit_bus = '0;
      evt_end = 0; rd_rdy = 0;
   endtask

   task automatic model_hits(logic [NL-1:0] v, logic [NL*WW-1:0] b);
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++)
            if (v[l] && b[l*WW +: WW] == mbank[p][l]) mflags[p][l] = 1'b1;
   endtask

   task automatic load(int p, int l, logic [WW-1:0] w);
      ld_we = 1; ld_pat = IW'(p); ld_layer = LW'(l); ld_word = w;
      @(negedge clk);
      ld_we = 0;
      mbank[p][l] = w;
   endtask

   task automatic set_thr(int v);
      thr_we = 1; thr_val = CW'(v);
      @(negedge clk);
      thr_we = 0;
      if (v >= 1 && v <= NL) mthr = v;
   endtask

   task automatic send_hits(logic [NL-1:0] v, logic [NL*WW-1:0] b);
      hit_vld = v; hit_bus = b;
      @(negedge clk);
      hit_vld = '0; hit_bus = '0;
      model_hits(v, b);
   endtask

   task automatic end_event(logic [NL-1:0] v, logic [NL*WW-1:0] b);
      evt_end = 1; hit_vld = v; hit_bus = b;
      @(negedge clk);
      evt_end = 0; hit_vld = '0; hit_bus = '0;
      model_hits(v, b);
   endtask

   task automatic drain(bit inject, int rdy_pct);
      int exp_ids[$];
      int ptr = 0;
      bit done = 0;
      int guard = 0;
      for (int p = 0; p < NP; p++)
         if (popc(mflags[p]) >= mthr) exp_ids.push_back(p);
      while (!done && guard < 400) begin
         bit r;
         guard++;
         if (ptr < exp_ids.size())
            chk("R6 R8 road beat", {29'd0, rd_vld, rd_eor, 1'b0} | 32'(rd_id) << 3,
                {29'd0, 1'b1, 1'b0, 1'b0} | 32'(exp_ids[ptr]) << 3);
         else
            chk("R7 eor beat", {29'd0, rd_vld, rd_eor, 1'b0} | 32'(rd_id) << 3,
                {29'd0, 1'b1, 1'b1, 1'b0});
         r = ($urandom % 100) < rdy_pct;
         rd_rdy = r;
         if (!r && inject) begin
            // R9 junk during readout, model untouched
            hit_vld = NL'($urandom); hit_bus = small_bus();
            ld_we = 1; ld_pat = IW'($urandom); ld_layer = LW'($urandom); ld_word = WW'($urandom % 4);
            thr_we = 1; thr_val = CW'($urandom % 9); evt_end = 1;
         end
         @(negedge clk);
         idle_inputs();
         if (r) begin
            if (ptr < exp_ids.size()) ptr++;
            else done = 1;
         end
      end
      for (int p = 0; p < NP; p++) mflags[p] = '0;
      chk("R7 back to collect", {31'd0, rd_vld}, 32'd0);
   endtask

   initial begin
      #500000;
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      for (int p = 0; p < NP; p++) begin
         mflags[p] = '0;
         for (int l = 0; l < NL; l++) mbank[p][l] = '0;
      end
      mthr = NL;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R5 reset idle", {31'd0, rd_vld}, 32'd0);

      // R1 R3: zero bank after reset, threshold 8, all-zero hits on every layer
      send_hits('1, '0);
      chk("R5 no vld while collecting", {31'd0, rd_vld}, 32'd0);
      end_event('0, '0);
      drain(0, 100);

      // R7: empty event right after a full one
      end_event('0, '0);
      drain(0, 100);

      // R4: invalid thresholds ignored, seven layers fall short of 8
      set_thr(0);
      set_thr(9);
      send_hits(8'h7F, '0);
      end_event('0, '0);
      drain(0, 50);

      // R3 R4: threshold of one
      set_thr(1);
      load(3, 5, 16'hBEEF);
      send_hits(8'h20, {NL{16'hBEEF}});
      end_event('0, '0);
      drain(0, 100);

      // R5: hits arriving with evt_end count
      set_thr(2);
      load(7, 0, 16'h1234);
      load(7, 1, 16'h5678);
      send_hits(8'h01, {112'd0, 16'h1234});
      end_event(8'h02, {96'd0, 16'h5678, 16'h0000});
      drain(1, 30);

      // random events
      for (int e = 0; e < 40; e++) begin
         int nl = $urandom % 6;
         int nh = 1 + $urandom % 5;
         for (int k = 0; k < nl; k++)
            load($urandom % NP, $urandom % NL, WW'($urandom % 4));
         if ($urandom % 3 == 0) set_thr($urandom % 11);
         for (int k = 0; k < nh; k++) send_hits(NL'($urandom), small_bus());
         end_event(NL'($urandom), small_bus());
         drain(1, 60);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule